// File: doc/BRIEF.md
# Signed Integer Divide and Modulo Unit

This block divides one signed integer by another over several clock cycles. Operands are 32 or 64 bits wide. It supports two ways of returning results. In legacy mode both results are produced on every operation: the quotient goes to a LO register port and the remainder goes to a HI register port. In release-6 mode a 5-bit selector chooses a single result, and that result goes out on a general destination write port. Selector value 2 returns the quotient and selector value 3 returns the remainder.

The unit works on the magnitudes of the operands. It uses restoring division and produces one quotient bit per clock. The signs are applied in a final step.

Two inputs give fixed outcomes:
- The most negative dividend divided by minus one gives the most negative value as quotient and zero as remainder.
- A zero divisor completes the operation but writes no register.

In release-6 mode, any other selector value is flagged as unimplemented and produces no write. A surrounding pipeline pulses `start`, waits for `done`, and commits whichever write enables are raised in that same cycle.

Top module: `divmod_unit`

## Requirements
- R1: In legacy mode with a nonzero divisor, `lo_we` and `hi_we` are both high in the `done` cycle. `lo_data` carries the quotient truncated toward zero. `hi_data` carries the remainder, which takes the sign of the dividend. `gpr_we` stays low.
- R2: In release-6 mode, selector 2 drives the quotient and selector 3 drives the remainder on `gpr_data`, with `gpr_we` high in the `done` cycle. `lo_we` and `hi_we` stay low.
- R3: In legacy mode, the most negative dividend of the chosen size divided by minus one gives LO = the most negative value and HI = 0.
- R4: In release-6 mode, the same overflow case gives the most negative value for selector 2 and zero for selector 3.
- R5: A zero divisor (judged on the low 32 bits only in 32-bit mode) raises `done` one clock after the start edge and raises no write enable.
- R6: In release-6 mode, a selector other than 2 or 3 raises `unimpl` together with `done`, one clock after the start edge, and raises no write enable. `unimpl` is low in every other case.
- R7: With `dword` low, only the low 32 bits of each operand are used, as signed values. Every written result is sign-extended to 64 bits.
- R8: A nonzero-divisor operation with a valid selector raises `done` 33 clocks (32-bit) or 65 clocks (64-bit) after the start edge, for exactly one cycle.
- R9: A `start` pulse that arrives while an operation is in progress is ignored. The running operation completes with its own operands.
- R10: In legacy mode the selector has no effect on the results or on the write enables.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation using the operands present at this edge |
| r6_mode | input | 1 | 1 = release-6 routing, 0 = legacy LO/HI routing |
| dword | input | 1 | 1 = 64-bit operands, 0 = 32-bit operands |
| sel | input | 5 | Release-6 result selector (2 = quotient, 3 = remainder) |
| dividend | input | 64 | Signed dividend |
| divisor | input | 64 | Signed divisor |
| lo_we | output | 1 | Write enable for LO (quotient) |
| lo_data | output | 64 | Value for LO |
| hi_we | output | 1 | Write enable for HI (remainder) |
| hi_data | output | 64 | Value for HI |
| gpr_we | output | 1 | Write enable for the general destination |
| gpr_data | output | 64 | Value for the general destination |
| unimpl | output | 1 | Selector was not recognised in release-6 mode |
| done | output | 1 | One-cycle completion pulse |

## Verification
The divide-by-zero test and the unimplemented-selector test can both be true for the same operation. Either one alone ends the operation early. The bench provokes the combination by issuing release-6 operations that have both a zero divisor and an unrecognised selector. It then requires `unimpl` high, no write enable at all, and `done` on the first clock after the start edge. A second overlap occurs when a fresh `start` lands while a run is in progress. That case is judged by the completion time and by the results of the operation that was already running.

// File: rtl/divmod_pkg.sv
// Package: shared constants and types for the divide/modulo unit.
// Assumes the selector field is 5 bits wide.
package divmod_pkg;
    localparam int unsigned SEL_W = 5;
    localparam logic [SEL_W-1:0] SEL_DIV = 5'd2;
    localparam logic [SEL_W-1:0] SEL_MOD = 5'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } dm_state_t;
endpackage

// File: rtl/divmod_ctrl.sv
// Sequencer: accepts start while idle, then issues one step per cycle for
// the operand width. It skips straight to finish when the operation needs
// no iteration. Assumes the short-path decision is valid at the start edge.
module divmod_ctrl
    import divmod_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dword,
    input  logic short_op,
    output logic load,
    output logic step,
    output logic finish
);
    localparam int unsigned HALF = XLEN / 2;
    localparam int unsigned CW   = $clog2(XLEN);

    dm_state_t       state;
    logic [CW-1:0]   cnt;

    // Decode the control strobes from the current state.
    always_comb begin
        load   = (state == ST_IDLE) && start;
        step   = (state == ST_RUN);
        finish = (state == ST_FIN);
    end

    // State register and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cnt   <= dword ? CW'(XLEN - 1) : CW'(HALF - 1);
                    state <= short_op ? ST_FIN : ST_RUN;
                end
                ST_RUN: begin
                    if (cnt == '0) state <= ST_FIN;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: once accepted, a start cannot be accepted again on the next cycle.
    assert_no_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    // R8: a run always leads to finish, never directly back to load.
    assert_run_ends_in_finish_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt == '0) |=> finish);
endmodule

// File: rtl/divmod_core.sv
// Restoring divider on operand magnitudes, one quotient bit per step.
// In 32-bit mode the low halves are sign-extended first. The dividend
// magnitude is pre-shifted into the upper half so that 32 steps suffice.
// Assumes the divisor is nonzero whenever steps are issued.
module divmod_core #(
    parameter int unsigned XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic            dword,
    input  logic [XLEN-1:0] dividend,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] quot_mag,
    output logic [XLEN-1:0] rem_mag,
    output logic            neg_q,
    output logic            neg_r
);
    localparam int unsigned HALF = XLEN / 2;

    logic [XLEN-1:0] ext_a, ext_b, mag_a, mag_b;
    logic [XLEN-1:0] q_q, dvs_q, rem_q;
    logic [XLEN:0]   rem_sh, diff;

    // Size-dependent sign extension and absolute value of the operands.
    always_comb begin
        ext_a = dword ? dividend : {{HALF{dividend[HALF-1]}}, dividend[HALF-1:0]};
        ext_b = dword ? divisor  : {{HALF{divisor[HALF-1]}},  divisor[HALF-1:0]};
        mag_a = ext_a[XLEN-1] ? (~ext_a + 1'b1) : ext_a;
        mag_b = ext_b[XLEN-1] ? (~ext_b + 1'b1) : ext_b;
    end

    // Trial subtraction for one restoring step.
    always_comb begin
        rem_sh = {rem_q, q_q[XLEN-1]};
        diff   = rem_sh - {1'b0, dvs_q};
    end

    // Load the magnitudes and signs, then shift in one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q   <= '0;
            dvs_q <= '0;
            rem_q <= '0;
            neg_q <= 1'b0;
            neg_r <= 1'b0;
        end else if (load) begin
            q_q   <= dword ? mag_a : (mag_a << HALF);
            dvs_q <= mag_b;
            rem_q <= '0;
            neg_q <= ext_a[XLEN-1] ^ ext_b[XLEN-1];
            neg_r <= ext_a[XLEN-1];
        end else if (step) begin
            if (!diff[XLEN]) begin
                rem_q <= diff[XLEN-1:0];
                q_q   <= {q_q[XLEN-2:0], 1'b1};
            end else begin
                rem_q <= rem_sh[XLEN-1:0];
                q_q   <= {q_q[XLEN-2:0], 1'b0};
            end
        end
    end

    assign quot_mag = q_q;
    assign rem_mag  = rem_q;

    // R1: the partial remainder stays below the divisor after every step.
    assert_rem_below_divisor_R1: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (rem_q < dvs_q));
endmodule

// File: rtl/divmod_route.sv
// Result stage: applies the signs, sign-extends 32-bit results, and routes
// them to LO/HI or to the general destination according to the mode
// captured at the start edge. Zero divisor and unknown selector suppress
// every write. Assumes finish lasts exactly one cycle per operation.
module divmod_route
    import divmod_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             finish,
    input  logic             r6_mode,
    input  logic             dword,
    input  logic [SEL_W-1:0] sel,
    input  logic             zero_div,
    input  logic             bad_sel,
    input  logic [XLEN-1:0]  quot_mag,
    input  logic [XLEN-1:0]  rem_mag,
    input  logic             neg_q,
    input  logic             neg_r,
    output logic             lo_we,
    output logic [XLEN-1:0]  lo_data,
    output logic             hi_we,
    output logic [XLEN-1:0]  hi_data,
    output logic             gpr_we,
    output logic [XLEN-1:0]  gpr_data,
    output logic             unimpl,
    output logic             done
);
    localparam int unsigned HALF = XLEN / 2;

    logic             r6_q, dword_q, zero_q, bad_q;
    logic [SEL_W-1:0] sel_q;
    logic [XLEN-1:0]  q_s, r_s, q_out, r_out;

    // Signed results, sign-extended from the half width in 32-bit mode.
    always_comb begin
        q_s   = neg_q ? (~quot_mag + 1'b1) : quot_mag;
        r_s   = neg_r ? (~rem_mag + 1'b1) : rem_mag;
        q_out = dword_q ? q_s : {{HALF{q_s[HALF-1]}}, q_s[HALF-1:0]};
        r_out = dword_q ? r_s : {{HALF{r_s[HALF-1]}}, r_s[HALF-1:0]};
    end

    // Capture the per-operation configuration at the start edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r6_q    <= 1'b0;
            dword_q <= 1'b0;
            zero_q  <= 1'b0;
            bad_q   <= 1'b0;
            sel_q   <= '0;
        end else if (load) begin
            r6_q    <= r6_mode;
            dword_q <= dword;
            zero_q  <= zero_div;
            bad_q   <= bad_sel;
            sel_q   <= sel;
        end
    end

    // Register the write strobes, data and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_we    <= 1'b0;
            hi_we    <= 1'b0;
            gpr_we   <= 1'b0;
            unimpl   <= 1'b0;
            done     <= 1'b0;
            lo_data  <= '0;
            hi_data  <= '0;
            gpr_data <= '0;
        end else begin
            lo_we  <= 1'b0;
            hi_we  <= 1'b0;
            gpr_we <= 1'b0;
            unimpl <= 1'b0;
            done   <= finish;
            if (finish) begin
                unimpl <= bad_q;
                if (!zero_q && !bad_q) begin
                    if (!r6_q) begin
                        lo_we   <= 1'b1;
                        hi_we   <= 1'b1;
                        lo_data <= q_out;
                        hi_data <= r_out;
                    end else begin
                        gpr_we   <= 1'b1;
                        gpr_data <= (sel_q == SEL_MOD) ? r_out : q_out;
                    end
                end
            end
        end
    end

    // R8: done is a single-cycle pulse.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R2: any write happens only in the done cycle.
    assert_write_only_at_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_we || hi_we || gpr_we) |-> done);
    // R2: legacy and release-6 routes never write together.
    assert_routes_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(gpr_we && (lo_we || hi_we)));
    // R1: LO and HI are always written as a pair.
    assert_lo_hi_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
        lo_we == hi_we);
    // R6: an unimplemented selector writes nothing.
    assert_unimpl_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        unimpl |-> !(lo_we || hi_we || gpr_we));
endmodule

// File: rtl/divmod_unit.sv
// Top level of the signed divide/modulo unit. It decodes the short-path
// cases (zero divisor, unknown release-6 selector) from the inputs at the
// start edge and wires the sequencer, the divider core and the result stage.
// Assumes operands stay valid during the start cycle only.
module divmod_unit
    import divmod_pkg::*;
#(
    parameter int unsigned XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             r6_mode,
    input  logic             dword,
    input  logic [SEL_W-1:0] sel,
    input  logic [XLEN-1:0]  dividend,
    input  logic [XLEN-1:0]  divisor,
    output logic             lo_we,
    output logic [XLEN-1:0]  lo_data,
    output logic             hi_we,
    output logic [XLEN-1:0]  hi_data,
    output logic             gpr_we,
    output logic [XLEN-1:0]  gpr_data,
    output logic             unimpl,
    output logic             done
);
    localparam int unsigned HALF = XLEN / 2;

    logic            zero_div, bad_sel, short_op;
    logic            load, step, finish;
    logic [XLEN-1:0] quot_mag, rem_mag;
    logic            neg_q, neg_r;

    // Decode the cases that finish without iterating.
    always_comb begin
        zero_div = dword ? (divisor == '0) : (divisor[HALF-1:0] == '0);
        bad_sel  = r6_mode && (sel != SEL_DIV) && (sel != SEL_MOD);
        short_op = zero_div || bad_sel;
    end

    divmod_ctrl #(.XLEN(XLEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .dword(dword),
        .short_op(short_op), .load(load), .step(step), .finish(finish)
    );

    divmod_core #(.XLEN(XLEN)) u_core (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step), .dword(dword),
        .dividend(dividend), .divisor(divisor), .quot_mag(quot_mag),
        .rem_mag(rem_mag), .neg_q(neg_q), .neg_r(neg_r)
    );

    divmod_route #(.XLEN(XLEN)) u_route (
        .clk(clk), .rst_n(rst_n), .load(load), .finish(finish),
        .r6_mode(r6_mode), .dword(dword), .sel(sel), .zero_div(zero_div),
        .bad_sel(bad_sel), .quot_mag(quot_mag), .rem_mag(rem_mag),
        .neg_q(neg_q), .neg_r(neg_r), .lo_we(lo_we), .lo_data(lo_data),
        .hi_we(hi_we), .hi_data(hi_data), .gpr_we(gpr_we),
        .gpr_data(gpr_data), .unimpl(unimpl), .done(done)
    );
endmodule

// File: tb/divmod_unit_tb.sv
// Directed bench for divmod_unit: one task per scenario, expected values
// from a signed arithmetic model of the requirements.
module divmod_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        r6_mode = 1'b0;
    logic        dword = 1'b0;
    logic [4:0]  sel = 5'd0;
    logic [63:0] dividend = '0;
    logic [63:0] divisor = '0;
    logic        lo_we, hi_we, gpr_we, unimpl, done;
    logic [63:0] lo_data, hi_data, gpr_data;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    divmod_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .r6_mode(r6_mode),
        .dword(dword), .sel(sel), .dividend(dividend), .divisor(divisor),
        .lo_we(lo_we), .lo_data(lo_data), .hi_we(hi_we), .hi_data(hi_data),
        .gpr_we(gpr_we), .gpr_data(gpr_data), .unimpl(unimpl), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model of the requirements: expected results and latency.
    task automatic model(input logic m, input logic dw, input logic [4:0] s,
                         input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] q, output logic [63:0] r,
                         output logic zero, output logic badsel, output int lat);
        longint sa, sb;
        sa = dw ? a : {{32{a[31]}}, a[31:0]};
        sb = dw ? b : {{32{b[31]}}, b[31:0]};
        zero   = (sb == 0);
        badsel = m && (s != 5'd2) && (s != 5'd3);
        q = '0; r = '0;
        if (!zero) begin
            if (sb == -1 && ((dw && sa == 64'sh8000_0000_0000_0000) ||
                             (!dw && sa == -64'sd2147483648))) begin
                q = sa; r = '0;
            end else begin
                q = sa / sb; r = sa % sb;
            end
        end
        lat = (zero || badsel) ? 1 : (dw ? 65 : 33);
    endtask

    // Issue one operation, wait for done, check latency, pulse and routing.
    task automatic run_op(input string tag, input logic m, input logic dw,
                          input logic [4:0] s, input logic [63:0] a, input logic [63:0] b);
        logic [63:0] q, r;
        logic zero, badsel;
        int exp_lat, lat;
        model(m, dw, s, a, b, q, r, zero, badsel, exp_lat);
        @(negedge clk);
        r6_mode = m; dword = dw; sel = s; dividend = a; divisor = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0; dividend = ~a; divisor = ~b;
        lat = 0;
        do begin
            @(posedge clk); @(negedge clk);
            lat++;
        end while (!done && lat < 200);
        chk({tag, " R8 latency"}, 64'(lat), 64'(exp_lat));
        chk({tag, " R6 unimpl"}, {63'd0, unimpl}, {63'd0, badsel});
        if (zero || badsel) begin
            chk({tag, " R5 no write"}, {61'd0, lo_we, hi_we, gpr_we}, 64'd0);
        end else if (!m) begin
            chk({tag, " R1 enables"}, {61'd0, lo_we, hi_we, gpr_we}, 64'd6);
            chk({tag, " R1 LO quotient"}, lo_data, q);
            chk({tag, " R1 HI remainder"}, hi_data, r);
        end else begin
            chk({tag, " R2 enables"}, {61'd0, lo_we, hi_we, gpr_we}, 64'd1);
            chk({tag, " R2 GPR result"}, gpr_data, (s == 5'd3) ? r : q);
        end
        @(negedge clk);
        chk({tag, " R8 done pulse"}, {62'd0, done, lo_we | hi_we | gpr_we}, 64'd0);
    endtask

    task automatic t_reset();
        chk("reset outputs", {59'd0, lo_we, hi_we, gpr_we, unimpl, done}, 64'd0);
    endtask

    task automatic t_legacy_signs();
        run_op("R1 +7/+2", 1'b0, 1'b0, 5'd0, 64'd7, 64'd2);
        run_op("R1 -7/+2", 1'b0, 1'b0, 5'd0, -64'sd7, 64'd2);
        run_op("R1 +7/-2", 1'b0, 1'b0, 5'd0, 64'd7, -64'sd2);
        run_op("R1 -7/-2", 1'b0, 1'b0, 5'd0, -64'sd7, -64'sd2);
        run_op("R1 64b big", 1'b0, 1'b1, 5'd0, 64'h7123_4567_89AB_CDEF, 64'h0000_0000_0012_3457);
        run_op("R1 64b neg", 1'b0, 1'b1, 5'd0, 64'h8000_0000_0000_0001, 64'd10);
    endtask

    task automatic t_r6_select();
        run_op("R2 div32", 1'b1, 1'b0, 5'd2, -64'sd100, 64'd7);
        run_op("R2 mod32", 1'b1, 1'b0, 5'd3, -64'sd100, 64'd7);
        run_op("R2 div64", 1'b1, 1'b1, 5'd2, 64'h0123_4567_0000_0000, -64'sd3);
        run_op("R2 mod64", 1'b1, 1'b1, 5'd3, 64'h0123_4567_0000_0001, -64'sd3);
    endtask

    task automatic t_overflow();
        run_op("R3 legacy32 min/-1", 1'b0, 1'b0, 5'd0, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
        run_op("R3 legacy64 min/-1", 1'b0, 1'b1, 5'd0, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R4 div32 min/-1", 1'b1, 1'b0, 5'd2, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
        run_op("R4 mod32 min/-1", 1'b1, 1'b0, 5'd3, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
        run_op("R4 div64 min/-1", 1'b1, 1'b1, 5'd2, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        run_op("R4 mod64 min/-1", 1'b1, 1'b1, 5'd3, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
    endtask

    task automatic t_zero_and_bad();
        run_op("R5 legacy zero", 1'b0, 1'b1, 5'd0, 64'd55, 64'd0);
        run_op("R5 r6 zero", 1'b1, 1'b0, 5'd3, 64'd55, 64'd0);
        run_op("R5 32b zero low half", 1'b0, 1'b0, 5'd0, 64'd55, 64'hABCD_0000_0000_0000);
        run_op("R6 sel0", 1'b1, 1'b0, 5'd0, 64'd9, 64'd4);
        run_op("R6 sel5", 1'b1, 1'b1, 5'd5, 64'd9, 64'd4);
        run_op("R6 sel31 zero div", 1'b1, 1'b0, 5'd31, 64'd9, 64'd0);
    endtask

    task automatic t_size_and_sel();
        run_op("R7 upper ignored", 1'b0, 1'b0, 5'd0, 64'hDEAD_BEEF_FFFF_FF9C, 64'h1234_5678_0000_0009);
        run_op("R7 r6 sign extend", 1'b1, 1'b0, 5'd2, 64'h0000_0000_F000_0000, 64'd3);
        run_op("R10 legacy sel7", 1'b0, 1'b0, 5'd7, 64'd1000, -64'sd33);
        run_op("R10 legacy sel2", 1'b0, 1'b1, 5'd2, 64'd1000, -64'sd33);
    endtask

    // R9: a second start during a run must not disturb it.
    task automatic t_busy_start();
        int lat;
        @(negedge clk);
        r6_mode = 1'b0; dword = 1'b0; sel = 5'd0;
        dividend = 64'd91; divisor = 64'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        dividend = 64'd3; divisor = 64'd0; r6_mode = 1'b1; sel = 5'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 6;
        while (!done && lat < 200) begin
            @(posedge clk); @(negedge clk);
            lat++;
        end
        chk("R9 latency unchanged", 64'(lat), 64'd33);
        chk("R9 enables of first op", {60'd0, lo_we, hi_we, gpr_we, unimpl}, 64'd12);
        chk("R9 LO of first op", lo_data, 64'd18);
        chk("R9 HI of first op", hi_data, 64'd1);
        @(negedge clk);
        chk("R9 no extra done", {63'd0, done}, 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_legacy_signs();
        t_r6_select();
        t_overflow();
        t_zero_and_bad();
        t_size_and_sel();
        t_busy_start();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule